// File: doc/BRIEF.md
# SPI Host FIFO Front End

This block is the host-facing data path of a SPI master. Software or a bus adapter loads outgoing bytes into a 64-byte transmit queue, either four at a time through a 32-bit word port or one at a time through a byte port. Incoming bytes collect in a 64-byte receive queue and are taken out through a word read port or a byte read port. Both queues store single bytes, so word and byte accesses can be mixed freely on the same queue.

The serial shifter sits outside the block. It takes transmit bytes through a valid/take handshake and delivers received bytes with a one-cycle valid strobe. A five-bit sticky status vector reports transmit-empty, word-available, byte-available, overflow and underflow. A clear-mask input removes flags by writing ones. A soft reset input flushes both queues and all flags without touching the global reset.

Top module: `spi_fifo_front`

## Requirements
- R1: While rst_n is low, and in the cycle after soft_rst is high at a clock edge, both queues are empty, tx_valid is 0, status is 5'b00000 and both read data outputs are 0.
- R2: A word push enqueues four bytes in little-endian order, so bits [7:0] leave first. A byte push enqueues one byte. When both ports push in the same cycle, the word's bytes go ahead of the single byte.
- R3: The transmit queue holds 64 bytes. A push that does not fit in the room counted at the start of the cycle is dropped as a whole and sets status bit 3 (overflow).
- R4: tx_valid is high exactly when the transmit queue holds a byte, and tx_data shows the oldest byte. A high tx_take removes that byte at the clock edge. tx_take while the queue is empty has no effect.
- R5: A word pop loads pop_word with the four oldest received bytes, the oldest in bits [7:0]. A byte pop loads pop_byte with the oldest byte. When both pop in one cycle, the word is served first. Results appear in the cycle after the request and hold until the next request on that port.
- R6: A pop that finds too few bytes loads 0 into its output, removes nothing and sets status bit 4 (underflow).
- R7: Status bit 0 (transmit empty) is set in the cycle after any clock edge at which the transmit queue is empty.
- R8: Status bit 1 (word available) is set after an edge at which the receive queue holds at least four bytes. Status bit 2 (byte available) is set after an edge at which it holds at least one byte.
- R9: Status bits stay set until cleared. A 1 in bit n of clr_mask clears bit n, and 5'b11111 clears all five bits.
- R10: Clearing bit 0, 1 or 2 while its condition still holds makes the bit read 0 for one cycle and 1 again in the following cycle. An overflow or underflow event in the same cycle as the clear of its bit leaves that bit set.
- R11: The receive queue holds 64 bytes. A byte arriving on rx_valid while it is full is dropped and sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of both queues and all flags |
| push_word_en | input | 1 | Push four bytes from push_word |
| push_word | input | 32 | Word to transmit, little-endian |
| push_byte_en | input | 1 | Push one byte from push_byte |
| push_byte | input | 8 | Byte to transmit |
| pop_word_en | input | 1 | Take four received bytes |
| pop_byte_en | input | 1 | Take one received byte |
| pop_word | output | 32 | Result of the last word pop |
| pop_byte | output | 8 | Result of the last byte pop |
| clr_mask | input | 5 | Write-one-to-clear strobes for the status bits |
| status | output | 5 | Sticky flags: 0 tx empty, 1 word ready, 2 byte ready, 3 overflow, 4 underflow |
| tx_valid | output | 1 | Transmit byte available to the shifter |
| tx_data | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Shifter consumes tx_data |
| rx_valid | input | 1 | Shifter delivers rx_data |
| rx_data | input | 8 | Received byte |

## Verification
Directed sequences come first. A word push and a byte push in the same cycle are drained to show lane order and word-before-byte ordering. A full-depth fill followed by one more push separates a whole-push drop from a partial write. A six-byte receive burst popped as word plus byte in one cycle shows the pop ordering, and a short word pop then exposes the zero result and the untouched remainder. Seeded random phases then alternate between fill-heavy and drain-heavy traffic so that both queues wrap and cross the full and empty boundaries under simultaneous host and shifter activity, with random clear masks and rare soft resets landing on flags whose conditions are still true.

// File: rtl/spi_ff_pkg.sv
package spi_ff_pkg;

  localparam int LANE_CW      = 3;
  localparam int ST_W         = 5;
  localparam int ST_TX_EMPTY  = 0;
  localparam int ST_RX_WORD   = 1;
  localparam int ST_RX_BYTE   = 2;
  localparam int ST_OVERFLOW  = 3;
  localparam int ST_UNDERFLOW = 4;
  localparam int N_LEVEL      = 3;

  // number of byte lanes moved for a word grant and a byte grant
  function automatic logic [LANE_CW-1:0] lane_count(input logic gw, input logic gb);
    return {gw, 1'b0, gb};
  endfunction

  // true when 'have' byte slots cover 'need'
  function automatic logic covers(input int unsigned have, input int unsigned need);
    return have >= need;
  endfunction

endpackage

// File: rtl/sff_lane_grant.sv
module sff_lane_grant
  import spi_ff_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic                want_word,
  input  logic                want_byte,
  input  logic [CNT_W-1:0]    room,
  output logic                grant_word,
  output logic                grant_byte,
  output logic [LANE_CW-1:0]  lanes,
  output logic                drop
);

  logic [CNT_W-1:0] left_after_word;

  always_comb begin
    grant_word      = want_word && covers(int'(room), 4);
    left_after_word = grant_word ? room - CNT_W'(4) : room;
    grant_byte      = want_byte && covers(int'(left_after_word), 1);
    lanes           = lane_count(grant_word, grant_byte);
    drop            = (want_word && !grant_word) || (want_byte && !grant_byte);
  end

endmodule

// File: rtl/sff_byte_fifo.sv
module sff_byte_fifo
  import spi_ff_pkg::*;
#(
  parameter  int DEPTH      = 64,
  parameter  int PUSH_LANES = 5,
  parameter  int POP_LANES  = 1,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [LANE_CW-1:0]        push_n,
  input  logic [PUSH_LANES*8-1:0]   push_bytes,
  input  logic [LANE_CW-1:0]        pop_n,
  output logic [POP_LANES*8-1:0]    head_bytes,
  output logic [CNT_W-1:0]          level
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int i = 0; i < PUSH_LANES; i++) begin
        if (LANE_CW'(i) < push_n) mem[wr_ptr + PTR_W'(i)] <= push_bytes[i*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      rd_ptr <= rd_ptr + PTR_W'(pop_n);
      level  <= level + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  for (genvar g = 0; g < POP_LANES; g++) begin : g_head
    assign head_bytes[g*8 +: 8] = mem[rd_ptr + PTR_W'(g)];
  end

endmodule

// File: rtl/sff_status.sv
module sff_status
  import spi_ff_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            tx_is_empty,
  input  logic            rx_has_word,
  input  logic            rx_has_byte,
  input  logic            overflow_evt,
  input  logic            underflow_evt,
  input  logic [ST_W-1:0] clr_mask,
  output logic [ST_W-1:0] flags
);

  logic [N_LEVEL-1:0]      level_cond;
  logic [ST_W-N_LEVEL-1:0] event_hit;

  assign level_cond = {rx_has_byte, rx_has_word, tx_is_empty};
  assign event_hit  = {underflow_evt, overflow_evt};

  // level flags: a clear beats the condition in its own cycle
  for (genvar g = 0; g < N_LEVEL; g++) begin : g_level
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               bit_q <= 1'b0;
      else if (flush)           bit_q <= 1'b0;
      else if (clr_mask[g])     bit_q <= 1'b0;
      else if (level_cond[g])   bit_q <= 1'b1;
    end
    assign flags[g] = bit_q;
  end

  // event flags: an event beats the clear in its own cycle
  for (genvar g = N_LEVEL; g < ST_W; g++) begin : g_event
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     bit_q <= 1'b0;
      else if (flush)                 bit_q <= 1'b0;
      else if (event_hit[g-N_LEVEL])  bit_q <= 1'b1;
      else if (clr_mask[g])           bit_q <= 1'b0;
    end
    assign flags[g] = bit_q;
  end

endmodule

// File: rtl/spi_fifo_front.sv
module spi_fifo_front
  import spi_ff_pkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        push_word_en,
  input  logic [31:0] push_word,
  input  logic        push_byte_en,
  input  logic [7:0]  push_byte,
  input  logic        pop_word_en,
  input  logic        pop_byte_en,
  output logic [31:0] pop_word,
  output logic [7:0]  pop_byte,
  input  logic [4:0]  clr_mask,
  output logic [4:0]  status,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_take,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data
);

  localparam int TX_CW     = $clog2(TX_DEPTH + 1);
  localparam int RX_CW     = $clog2(RX_DEPTH + 1);
  localparam int HOST_LANE = 5;

  // named internal events
  logic [TX_CW-1:0]        tx_level;
  logic [TX_CW-1:0]        tx_room;
  logic [RX_CW-1:0]        rx_level;
  logic                    tx_gw, tx_gb, tx_drop;
  logic                    rx_gw, rx_gb, rx_host_drop;
  logic [LANE_CW-1:0]      tx_push_n, rx_pop_n;
  logic [HOST_LANE*8-1:0]  tx_push_bytes;
  logic [HOST_LANE*8-1:0]  rx_head;
  logic                    tx_line_pop;
  logic                    rx_line_accept;
  logic                    rx_line_drop;
  logic                    overflow_evt;
  logic                    underflow_evt;

  assign tx_room = TX_CW'(TX_DEPTH) - tx_level;

  sff_lane_grant #(.CNT_W(TX_CW)) u_tx_grant (
    .want_word  (push_word_en),
    .want_byte  (push_byte_en),
    .room       (tx_room),
    .grant_word (tx_gw),
    .grant_byte (tx_gb),
    .lanes      (tx_push_n),
    .drop       (tx_drop)
  );

  sff_lane_grant #(.CNT_W(RX_CW)) u_rx_grant (
    .want_word  (pop_word_en),
    .want_byte  (pop_byte_en),
    .room       (rx_level),
    .grant_word (rx_gw),
    .grant_byte (rx_gb),
    .lanes      (rx_pop_n),
    .drop       (rx_host_drop)
  );

  // the lone byte rides in lane 4 behind a word, else in lane 0
  assign tx_push_bytes = tx_gw ? {push_byte, push_word} : {32'h0, push_byte};
  assign tx_line_pop   = tx_take && (tx_level != '0);
  assign tx_valid      = (tx_level != '0);

  sff_byte_fifo #(.DEPTH(TX_DEPTH), .PUSH_LANES(HOST_LANE), .POP_LANES(1)) u_tx_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (soft_rst),
    .push_n     (tx_push_n),
    .push_bytes (tx_push_bytes),
    .pop_n      ({{(LANE_CW-1){1'b0}}, tx_line_pop}),
    .head_bytes (tx_data),
    .level      (tx_level)
  );

  assign rx_line_accept = rx_valid && (rx_level != RX_CW'(RX_DEPTH));
  assign rx_line_drop   = rx_valid && !rx_line_accept;

  sff_byte_fifo #(.DEPTH(RX_DEPTH), .PUSH_LANES(1), .POP_LANES(HOST_LANE)) u_rx_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (soft_rst),
    .push_n     ({{(LANE_CW-1){1'b0}}, rx_line_accept}),
    .push_bytes (rx_data),
    .pop_n      (rx_pop_n),
    .head_bytes (rx_head),
    .level      (rx_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_word <= '0;
      pop_byte <= '0;
    end else if (soft_rst) begin
      pop_word <= '0;
      pop_byte <= '0;
    end else begin
      if (pop_word_en) pop_word <= rx_gw ? rx_head[31:0] : 32'h0;
      if (pop_byte_en) pop_byte <= rx_gb ? (rx_gw ? rx_head[39:32] : rx_head[7:0]) : 8'h0;
    end
  end

  assign overflow_evt  = tx_drop || rx_line_drop;
  assign underflow_evt = rx_host_drop;

  sff_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (soft_rst),
    .tx_is_empty   (tx_level == '0),
    .rx_has_word   (rx_level >= RX_CW'(4)),
    .rx_has_byte   (rx_level != '0),
    .overflow_evt  (overflow_evt),
    .underflow_evt (underflow_evt),
    .clr_mask      (clr_mask),
    .flags         (status)
  );

endmodule

// File: rtl/sff_checker.sv
module sff_checker #(
  parameter  int TX_DEPTH = 64,
  parameter  int RX_DEPTH = 64,
  localparam int TX_CW    = $clog2(TX_DEPTH + 1),
  localparam int RX_CW    = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             push_word_en,
  input logic             push_byte_en,
  input logic             pop_word_en,
  input logic             pop_byte_en,
  input logic [7:0]       pop_byte,
  input logic [4:0]       clr_mask,
  input logic [4:0]       status,
  input logic             tx_valid,
  input logic [TX_CW-1:0] tx_level,
  input logic [RX_CW-1:0] rx_level
);

  // R1
  soft_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status == 5'b0 && !tx_valid && rx_level == '0));

  // R3
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= TX_CW'(TX_DEPTH));

  // R11
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= RX_CW'(RX_DEPTH));

  // R4
  no_phantom_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !push_word_en && !push_byte_en) |=> !tx_valid);

  // R7
  tx_empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0 && !clr_mask[0] && !soft_rst) |=> status[0]);

  // R8
  rx_word_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= RX_CW'(4) && !clr_mask[1] && !soft_rst) |=> status[1]);

  // R6
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_byte_en && !pop_word_en && rx_level == '0 && !soft_rst) |=> (status[4] && pop_byte == 8'h0));

  // R9
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !clr_mask[3] && !soft_rst) |=> status[3]);

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_mask[0] |=> !status[0]);

endmodule

bind spi_fifo_front sff_checker #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_sff_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_rst     (soft_rst),
  .push_word_en (push_word_en),
  .push_byte_en (push_byte_en),
  .pop_word_en  (pop_word_en),
  .pop_byte_en  (pop_byte_en),
  .pop_byte     (pop_byte),
  .clr_mask     (clr_mask),
  .status       (status),
  .tx_valid     (tx_valid),
  .tx_level     (tx_level),
  .rx_level     (rx_level)
);

// File: tb/spi_fifo_front_bench.sv
module spi_fifo_front_bench;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        push_word_en = 1'b0;
  logic [31:0] push_word = '0;
  logic        push_byte_en = 1'b0;
  logic [7:0]  push_byte = '0;
  logic        pop_word_en = 1'b0;
  logic        pop_byte_en = 1'b0;
  logic [31:0] pop_word;
  logic [7:0]  pop_byte;
  logic [4:0]  clr_mask = '0;
  logic [4:0]  status;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_take = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;

  always #4 clk = ~clk;

  spi_fifo_front u_spi_fifo_front (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .push_word_en(push_word_en), .push_word(push_word),
    .push_byte_en(push_byte_en), .push_byte(push_byte),
    .pop_word_en(pop_word_en), .pop_byte_en(pop_byte_en),
    .pop_word(pop_word), .pop_byte(pop_byte),
    .clr_mask(clr_mask), .status(status),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  logic [7:0]  m_tx[$];
  logic [7:0]  m_rx[$];
  logic [4:0]  m_st = '0;
  logic [31:0] m_rw = '0;
  logic [7:0]  m_rb = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic pct(input int p);
    return int'($urandom % 100) < p;
  endfunction

  task automatic model_clear();
    m_tx.delete();
    m_rx.delete();
    m_st = '0;
    m_rw = '0;
    m_rb = '0;
  endtask

  // model of one clock edge, driven from the requirements
  task automatic model_edge();
    int txn = m_tx.size();
    int rxn = m_rx.size();
    logic gw, gb, rgw, rgb, ovf, unf;
    logic [2:0] cond;
    if (soft_rst) begin
      model_clear();
      return;
    end
    gw  = push_word_en && (DEPTH - txn) >= 4;
    gb  = push_byte_en && (DEPTH - txn - (gw ? 4 : 0)) >= 1;
    rgw = pop_word_en && rxn >= 4;
    rgb = pop_byte_en && (rxn - (rgw ? 4 : 0)) >= 1;
    ovf = (push_word_en && !gw) || (push_byte_en && !gb) || (rx_valid && rxn >= DEPTH);
    unf = (pop_word_en && !rgw) || (pop_byte_en && !rgb);
    cond = {rxn >= 1, rxn >= 4, txn == 0};
    for (int i = 0; i < 3; i++) m_st[i] = clr_mask[i] ? 1'b0 : (m_st[i] | cond[i]);
    m_st[3] = ovf | (m_st[3] & ~clr_mask[3]);
    m_st[4] = unf | (m_st[4] & ~clr_mask[4]);
    if (pop_word_en) begin
      if (rgw) begin
        m_rw = {m_rx[3], m_rx[2], m_rx[1], m_rx[0]};
        for (int i = 0; i < 4; i++) void'(m_rx.pop_front());
      end else m_rw = '0;
    end
    if (pop_byte_en) begin
      if (rgb) m_rb = m_rx.pop_front();
      else     m_rb = '0;
    end
    if (rx_valid && rxn < DEPTH) m_rx.push_back(rx_data);
    if (tx_take && txn != 0) void'(m_tx.pop_front());
    if (gw) for (int i = 0; i < 4; i++) m_tx.push_back(push_word[i*8 +: 8]);
    if (gb) m_tx.push_back(push_byte);
  endtask

  task automatic compare();
    chk("R7", "tx empty flag", 32'(status[0]), 32'(m_st[0]));
    chk("R8", "word ready flag", 32'(status[1]), 32'(m_st[1]));
    chk("R8", "byte ready flag", 32'(status[2]), 32'(m_st[2]));
    chk("R3", "overflow flag", 32'(status[3]), 32'(m_st[3]));
    chk("R6", "underflow flag", 32'(status[4]), 32'(m_st[4]));
    chk("R5", "pop_word", pop_word, m_rw);
    chk("R5", "pop_byte", 32'(pop_byte), 32'(m_rb));
    chk("R4", "tx_valid", 32'(tx_valid), 32'(m_tx.size() != 0));
    if (m_tx.size() != 0) chk("R2", "tx_data", 32'(tx_data), 32'(m_tx[0]));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    soft_rst = 0; push_word_en = 0; push_byte_en = 0; pop_word_en = 0;
    pop_byte_en = 0; clr_mask = '0; tx_take = 0; rx_valid = 0;
  endtask

  task automatic rand_phase(input int cycles, input int pw, input int pb, input int tk,
                            input int rv, input int ow, input int ob);
    for (int c = 0; c < cycles; c++) begin
      push_word_en = pct(pw); push_word = $urandom;
      push_byte_en = pct(pb); push_byte = 8'($urandom);
      tx_take = pct(tk);
      rx_valid = pct(rv); rx_data = 8'($urandom);
      pop_word_en = pct(ow); pop_byte_en = pct(ob);
      clr_mask = pct(6) ? 5'($urandom) : 5'b0;
      soft_rst = ($urandom % 400) == 0;
      step();
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] exp_order [5];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "status in reset", 32'(status), 32'h0);
    chk("R1", "tx_valid in reset", 32'(tx_valid), 32'h0);
    chk("R1", "pop_word in reset", pop_word, 32'h0);
    rst_n = 1'b1;
    model_clear();
    step();
    chk("R7", "tx empty after reset", 32'(status[0]), 32'h1);

    // R2: lane order and word-before-byte
    push_word_en = 1; push_word = 32'h44332211;
    push_byte_en = 1; push_byte = 8'h55;
    step();
    exp_order = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    for (int k = 0; k < 5; k++) begin
      chk("R2", "drain order", 32'(tx_data), 32'(exp_order[k]));
      tx_take = 1;
      step();
    end
    chk("R4", "empty after drain", 32'(tx_valid), 32'h0);
    tx_take = 1;
    step();
    chk("R4", "take on empty ignored", 32'(tx_valid), 32'h0);

    // R3: fill to capacity, then one more push
    for (int k = 0; k < 16; k++) begin
      push_word_en = 1; push_word = 32'h03020100 + 32'h04040404 * k;
      step();
    end
    chk("R3", "no overflow at exactly full", 32'(status[3]), 32'h0);
    push_byte_en = 1; push_byte = 8'hEE;
    step();
    chk("R3", "overflow on push into full", 32'(status[3]), 32'h1);
    for (int k = 0; k < 64; k++) begin
      chk("R3", "stored byte", 32'(tx_data), 32'(k));
      tx_take = 1;
      step();
    end
    chk("R3", "dropped byte absent", 32'(tx_valid), 32'h0);
    clr_mask = 5'b01000;
    step();
    chk("R9", "overflow cleared", 32'(status[3]), 32'h0);

    // R10: clear while tx still empty
    step();
    clr_mask = 5'b00001;
    step();
    chk("R10", "cleared level flag", 32'(status[0]), 32'h0);
    step();
    chk("R10", "level flag returns", 32'(status[0]), 32'h1);

    // R5 / R8: receive six bytes, pop word and byte together
    for (int k = 0; k < 6; k++) begin
      rx_valid = 1; rx_data = 8'hA0 + 8'(k);
      step();
    end
    step();
    chk("R8", "word ready", 32'(status[1]), 32'h1);
    chk("R8", "byte ready", 32'(status[2]), 32'h1);
    pop_word_en = 1; pop_byte_en = 1;
    step();
    chk("R5", "word pop order", pop_word, 32'hA3A2A1A0);
    chk("R5", "byte after word", 32'(pop_byte), 32'hA4);
    // R6: short word pop
    pop_word_en = 1;
    step();
    chk("R6", "short word pop is zero", pop_word, 32'h0);
    chk("R6", "underflow set", 32'(status[4]), 32'h1);
    pop_byte_en = 1; clr_mask = 5'b10000;
    step();
    chk("R6", "remaining byte kept", 32'(pop_byte), 32'hA5);
    chk("R10", "underflow cleared", 32'(status[4]), 32'h0);
    pop_byte_en = 1; clr_mask = 5'b10000;
    step();
    chk("R10", "event beats clear", 32'(status[4]), 32'h1);

    // R11: receive overrun
    for (int k = 0; k < 65; k++) begin
      rx_valid = 1; rx_data = 8'(k);
      step();
    end
    chk("R11", "rx overflow", 32'(status[3]), 32'h1);
    for (int k = 0; k < 16; k++) begin
      pop_word_en = 1;
      step();
      chk("R11", "rx word", pop_word, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    end

    // R9: clear everything
    clr_mask = 5'b11111;
    step();
    chk("R9", "clear all", 32'(status), 32'h0);

    // R1: soft reset with data queued
    push_word_en = 1; push_word = 32'hDEADBEEF;
    rx_valid = 1; rx_data = 8'h77;
    step();
    soft_rst = 1;
    step();
    chk("R1", "soft reset status", 32'(status), 32'h0);
    chk("R1", "soft reset tx", 32'(tx_valid), 32'h0);

    rand_phase(800, 40, 30, 10, 60, 5, 5);
    rand_phase(800, 10, 10, 80, 10, 30, 30);
    rand_phase(800, 25, 25, 30, 30, 15, 20);
    rand_phase(800, 50, 40, 5, 80, 2, 2);
    rand_phase(800, 5, 5, 90, 5, 40, 40);

    finish_run();
  end

endmodule